// File: doc/BRIEF.md
# Command-Processor Microcontroller ALU

This block is the arithmetic/logic unit of a small 32-bit microcontroller that walks a command stream and programs hardware registers. Each instruction supplies an opcode, a first source, and a second operand that comes either from a register or from a 16-bit immediate field of the instruction. The result and the carry-out are produced combinationally in the same cycle, so the surrounding pipeline can write the result back without an extra stage.

Two features serve the firmware's control flow. The three-way compare yields fixed bit patterns, so that a later branch testing a single bit can decide greater-than, less-than-or-equal and their relatives without a separate flags word. The high-word add and subtract forms take a carry or borrow in, so that 64-bit addresses and counters are handled as two 32-bit steps. A one-bit carry flag register holds the carry of the last arithmetic instruction and is meant to be fed back to the carry input of the next high-word step.

Top module: `ucalu_core`

## Requirements
- R1: When `use_imm` is 1 the second operand is `imm` zero-extended to 32 bits; when it is 0 the second operand is `src2_reg`. All operations below name this value "operand 2".
- R2: Opcode 0 (add) returns src1 + operand 2 modulo 2^32 with `carry_out` the carry from bit 31; opcode 2 (subtract) returns src1 - operand 2 modulo 2^32 with `carry_out` 1 exactly when operand 2 is greater than src1 (a borrow). Every opcode other than 0 to 3 drives `carry_out` to 0.
- R3: Opcode 1 (add-high) returns src1 + operand 2 + `carry_in`; opcode 3 (subtract-high) returns src1 - operand 2 - `carry_in`, with `carry_out` the carry or borrow of that full operation, so chaining a low step and a high step yields the correct 64-bit sum or difference.
- R4: Opcodes 4, 5 and 6 return the bitwise AND, OR and XOR of src1 and operand 2; opcode 7 returns the bitwise inverse of operand 2 and src1 has no effect on it.
- R5: Opcode 8 shifts src1 left, opcode 9 shifts it right filling with zeros, opcode 10 shifts it right replicating bit 31; the amount is bits 4:0 of operand 2 and higher bits of operand 2 have no effect.
- R6: Opcode 11 rotates src1 left by bits 4:0 of operand 2, bits leaving bit 31 re-entering at bit 0.
- R7: Opcode 12 multiplies bits 7:0 of src1 by bits 7:0 of operand 2 and returns the 16-bit product in bits 15:0 with bits 31:16 zero.
- R8: Opcode 13 compares src1 and operand 2 as unsigned numbers and returns 0x00 when src1 is greater, 0x2b when equal and 0x1e when src1 is less.
- R9: `carry_flag` is 0 after reset; at a clock edge with `op_valid` 1 and opcode 0 to 3 it takes the value of `carry_out`, and at every other edge it keeps its value.
- R10: Opcodes 14 and 15 are reserved: result 0, `carry_out` 0, and `carry_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the carry flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Instruction present this cycle; enables the carry flag update |
| opcode | input | 4 | Operation select, values 0 to 15 |
| src1 | input | 32 | First source operand |
| src2_reg | input | 32 | Second source from the register file |
| imm | input | 16 | Immediate field of the instruction |
| use_imm | input | 1 | 1 selects the zero-extended immediate as operand 2 |
| carry_in | input | 1 | Carry or borrow into the high-word operations |
| result | output | 32 | Combinational result |
| carry_out | output | 1 | Combinational carry or borrow of the arithmetic operations |
| carry_flag | output | 1 | Registered carry of the last valid arithmetic operation |

## Verification
The checker watches, on every cycle, the invariants that hold for any operand values: the carry flag capturing or holding according to the opcode and valid, a compare result being one of its three codes, the multiply never setting bits above 15, an immediate AND never setting the upper half, logic opcodes never raising carry, and reserved opcodes returning zero. The exact values of sums, differences, shifted and rotated words, the 64-bit carry chain across two instructions, unsigned ordering of the compare near the sign bit and the masking of the shift amount only show through the bench's scenarios, which compare each result with a model built from the requirements.

// File: rtl/ucalu_pkg.sv
package ucalu_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_ADDHI = 4'd1,
      OP_SUB   = 4'd2,
      OP_SUBHI = 4'd3,
      OP_AND   = 4'd4,
      OP_OR    = 4'd5,
      OP_XOR   = 4'd6,
      OP_NOT   = 4'd7,
      OP_SHL   = 4'd8,
      OP_USHR  = 4'd9,
      OP_ISHR  = 4'd10,
      OP_ROT   = 4'd11,
      OP_MUL8  = 4'd12,
      OP_CMP   = 4'd13
   } alu_op_e;

   typedef enum logic [1:0] {
      SK_LEFT   = 2'd0,
      SK_RLOG   = 2'd1,
      SK_RARITH = 2'd2,
      SK_ROTL   = 2'd3
   } shift_kind_e;

   localparam logic [7:0] CMP_CODE_GT = 8'h00;
   localparam logic [7:0] CMP_CODE_EQ = 8'h2b;
   localparam logic [7:0] CMP_CODE_LT = 8'h1e;

   function automatic logic op_is_arith(input logic [3:0] op);
      return (op == OP_ADD) || (op == OP_ADDHI) || (op == OP_SUB) || (op == OP_SUBHI);
   endfunction

   function automatic logic op_is_shift(input logic [3:0] op);
      return (op == OP_SHL) || (op == OP_USHR) || (op == OP_ISHR) || (op == OP_ROT);
   endfunction

endpackage

// File: rtl/ucalu_opsel.sv
module ucalu_opsel #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [DATA_W-1:0] src2_reg,
   input  logic [IMM_W-1:0]  imm,
   input  logic              use_imm,
   output logic [DATA_W-1:0] op2
);
   localparam int PAD_W = DATA_W - IMM_W;

   generate
      if (IMM_W > DATA_W) begin : g_bad_imm
         $error("ucalu_opsel: IMM_W must not exceed DATA_W");
      end
      if (PAD_W == 0) begin : g_full
         assign op2 = use_imm ? imm : src2_reg;
      end else begin : g_pad
         assign op2 = use_imm ? {{PAD_W{1'b0}}, imm} : src2_reg;
      end
   endgenerate

endmodule

// File: rtl/ucalu_addsub.sv
module ucalu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              do_sub,
   input  logic              chain,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout
);
   logic [DATA_W-1:0] b_eff;
   logic              c_eff;
   logic [DATA_W:0]   wide;

   // subtract is a + ~b + 1; a chained subtract removes the incoming borrow
   assign b_eff = do_sub ? ~b : b;

   always_comb begin
      if (do_sub) c_eff = chain ? ~cin : 1'b1;
      else        c_eff = chain ?  cin : 1'b0;
   end

   assign wide = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
   assign sum  = wide[DATA_W-1:0];
   // carry out of the adder is the inverse of the borrow when subtracting
   assign cout = do_sub ? ~wide[DATA_W] : wide[DATA_W];

endmodule

// File: rtl/ucalu_shift.sv
module ucalu_shift
   import ucalu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int STAGED = 1,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] a,
   input  logic [AMT_W-1:0]  amt,
   input  shift_kind_e       kind,
   output logic [DATA_W-1:0] y
);

   generate
      if ((1 << AMT_W) != DATA_W) begin : g_bad_w
         $error("ucalu_shift: DATA_W must be a power of two");
      end

      if (STAGED != 0) begin : g_staged
         logic [DATA_W-1:0] stg [0:AMT_W];
         assign stg[0] = a;
         for (genvar i = 0; i < AMT_W; i++) begin : g_stage
            localparam int S = 1 << i;
            logic [DATA_W-1:0] x;
            logic [DATA_W-1:0] moved;
            assign x = stg[i];
            always_comb begin
               unique case (kind)
                  SK_LEFT:   moved = x << S;
                  SK_RLOG:   moved = x >> S;
                  SK_RARITH: moved = $unsigned($signed(x) >>> S);
                  default:   moved = {x[DATA_W-1-S:0], x[DATA_W-1:DATA_W-S]};
               endcase
            end
            assign stg[i+1] = amt[i] ? moved : x;
         end
         assign y = stg[AMT_W];
      end else begin : g_flat
         logic [2*DATA_W-1:0] dbl;
         assign dbl = {a, a} << amt;
         always_comb begin
            unique case (kind)
               SK_LEFT:   y = a << amt;
               SK_RLOG:   y = a >> amt;
               SK_RARITH: y = $unsigned($signed(a) >>> amt);
               default:   y = dbl[2*DATA_W-1:DATA_W];
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/ucalu_logic.sv
module ucalu_logic
   import ucalu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int MUL_W  = 8
) (
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   localparam int PROD_W = 2 * MUL_W;

   logic [PROD_W-1:0] prod;
   logic [DATA_W-1:0] cmp_code;

   generate
      if (PROD_W > DATA_W) begin : g_bad_mul
         $error("ucalu_logic: product of MUL_W bits must fit in DATA_W");
      end
      if (DATA_W < 8) begin : g_bad_cmp
         $error("ucalu_logic: compare codes need DATA_W of at least 8");
      end
   endgenerate

   assign prod = a[MUL_W-1:0] * b[MUL_W-1:0];

   always_comb begin
      if (a > b)       cmp_code = DATA_W'(CMP_CODE_GT);
      else if (a == b) cmp_code = DATA_W'(CMP_CODE_EQ);
      else             cmp_code = DATA_W'(CMP_CODE_LT);
   end

   always_comb begin
      unique case (op)
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_NOT:  y = ~b;
         OP_MUL8: y = DATA_W'(prod);
         OP_CMP:  y = cmp_code;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/ucalu_core.sv
module ucalu_core
   import ucalu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int IMM_W        = 16,
   parameter int MUL_W        = 8,
   parameter int SHIFT_STAGED = 1,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        opcode,
   input  logic [DATA_W-1:0] src1,
   input  logic [DATA_W-1:0] src2_reg,
   input  logic [IMM_W-1:0]  imm,
   input  logic              use_imm,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              carry_out,
   output logic              carry_flag
);

   logic [DATA_W-1:0] op2;
   logic [DATA_W-1:0] as_sum;
   logic              as_cout;
   logic [DATA_W-1:0] sh_y;
   logic [DATA_W-1:0] lg_y;
   logic              is_sub;
   logic              is_chain;
   shift_kind_e       kind;

   ucalu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_opsel (
      .src2_reg (src2_reg),
      .imm      (imm),
      .use_imm  (use_imm),
      .op2      (op2)
   );

   assign is_sub   = (opcode == OP_SUB)   || (opcode == OP_SUBHI);
   assign is_chain = (opcode == OP_ADDHI) || (opcode == OP_SUBHI);

   ucalu_addsub #(.DATA_W(DATA_W)) i_addsub (
      .a      (src1),
      .b      (op2),
      .do_sub (is_sub),
      .chain  (is_chain),
      .cin    (carry_in),
      .sum    (as_sum),
      .cout   (as_cout)
   );

   always_comb begin
      unique case (opcode)
         OP_USHR: kind = SK_RLOG;
         OP_ISHR: kind = SK_RARITH;
         OP_ROT:  kind = SK_ROTL;
         default: kind = SK_LEFT;
      endcase
   end

   ucalu_shift #(.DATA_W(DATA_W), .STAGED(SHIFT_STAGED)) i_shift (
      .a    (src1),
      .amt  (op2[AMT_W-1:0]),
      .kind (kind),
      .y    (sh_y)
   );

   ucalu_logic #(.DATA_W(DATA_W), .MUL_W(MUL_W)) i_logic (
      .op (opcode),
      .a  (src1),
      .b  (op2),
      .y  (lg_y)
   );

   always_comb begin
      if (op_is_arith(opcode))      result = as_sum;
      else if (op_is_shift(opcode)) result = sh_y;
      else                          result = lg_y;
   end

   assign carry_out = op_is_arith(opcode) ? as_cout : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                carry_flag <= 1'b0;
      else if (op_valid && op_is_arith(opcode))  carry_flag <= carry_out;
   end

endmodule

// File: rtl/ucalu_core_chk.sv
module ucalu_core_chk
   import ucalu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int MUL_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [3:0]        opcode,
   input logic [DATA_W-1:0] src1,
   input logic [DATA_W-1:0] src2_reg,
   input logic [IMM_W-1:0]  imm,
   input logic              use_imm,
   input logic              carry_in,
   input logic [DATA_W-1:0] result,
   input logic              carry_out,
   input logic              carry_flag
);

   a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_is_arith(opcode)) |=> (carry_flag == $past(carry_out)));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid || !op_is_arith(opcode)) |=> $stable(carry_flag));

   a_r8_code_set: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_CMP) |->
         (result == DATA_W'(CMP_CODE_GT) || result == DATA_W'(CMP_CODE_EQ) ||
          result == DATA_W'(CMP_CODE_LT)));

   a_r8_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_CMP && !use_imm && src1 == src2_reg) |-> (result == DATA_W'(CMP_CODE_EQ)));

   a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_MUL8) |-> (result[DATA_W-1:2*MUL_W] == '0));

   a_r1_imm_and: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_AND && use_imm) |-> (result[DATA_W-1:IMM_W] == '0));

   a_r4_xor_self: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_XOR && !use_imm && src1 == src2_reg) |-> (result == '0));

   a_r2_no_carry_other: assert property (@(posedge clk) disable iff (!rst_n)
      !op_is_arith(opcode) |-> !carry_out);

   a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode >= 4'd14) |-> (result == '0));

endmodule

bind ucalu_core ucalu_core_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .MUL_W(MUL_W)) i_ucalu_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .opcode     (opcode),
   .src1       (src1),
   .src2_reg   (src2_reg),
   .imm        (imm),
   .use_imm    (use_imm),
   .carry_in   (carry_in),
   .result     (result),
   .carry_out  (carry_out),
   .carry_flag (carry_flag)
);

// File: tb/test_ucalu_core.sv
module test_ucalu_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  opcode = 4'd0;
   logic [31:0] src1 = '0;
   logic [31:0] src2_reg = '0;
   logic [15:0] imm = '0;
   logic        use_imm = 1'b0;
   logic        carry_in = 1'b0;
   logic [31:0] result;
   logic        carry_out;
   logic        carry_flag;

   int n_cmp = 0;
   int n_bad = 0;
   logic exp_flag = 1'b0;

   logic [31:0] q_res  [$];
   logic        q_cout [$];
   logic        q_flag [$];
   string       q_tag  [$];

   always #10 clk = ~clk;

   ucalu_core i_ucalu_core (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
      .src1(src1), .src2_reg(src2_reg), .imm(imm), .use_imm(use_imm),
      .carry_in(carry_in), .result(result), .carry_out(carry_out),
      .carry_flag(carry_flag)
   );

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd2:             return "R2";
         4'd1, 4'd3:             return "R3";
         4'd4, 4'd5, 4'd6, 4'd7: return "R4";
         4'd8, 4'd9, 4'd10:      return "R5";
         4'd11:                  return "R6";
         4'd12:                  return "R7";
         4'd13:                  return "R8";
         default:                return "R10";
      endcase
   endfunction

   task automatic drv(input logic v, input logic [3:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] im,
                      input logic ui, input logic ci);
      logic [31:0] o2, r;
      logic [32:0] w;
      logic        c;
      @(negedge clk);
      op_valid = v; opcode = op; src1 = a; src2_reg = b;
      imm = im; use_imm = ui; carry_in = ci;
      o2 = ui ? {16'h0000, im} : b;
      c = 1'b0;
      case (op)
         4'd0:  begin w = {1'b0, a} + {1'b0, o2};      r = w[31:0]; c = w[32]; end
         4'd1:  begin w = {1'b0, a} + {1'b0, o2} + 33'(ci); r = w[31:0]; c = w[32]; end
         4'd2:  begin r = a - o2;      c = (o2 > a); end
         4'd3:  begin r = a - o2 - 32'(ci); c = ({1'b0, o2} + 33'(ci)) > {1'b0, a}; end
         4'd4:  r = a & o2;
         4'd5:  r = a | o2;
         4'd6:  r = a ^ o2;
         4'd7:  r = ~o2;
         4'd8:  r = a << o2[4:0];
         4'd9:  r = a >> o2[4:0];
         4'd10: r = $unsigned($signed(a) >>> o2[4:0]);
         4'd11: r = (a << o2[4:0]) | ((o2[4:0] == 5'd0) ? 32'd0 : (a >> (6'd32 - {1'b0, o2[4:0]})));
         4'd12: r = {16'h0000, 16'(a[7:0]) * 16'(o2[7:0])};
         4'd13: r = (a > o2) ? 32'h00 : ((a == o2) ? 32'h2b : 32'h1e);
         default: r = 32'd0;
      endcase
      if (v && op <= 4'd3) exp_flag = c;
      q_res.push_back(r);
      q_cout.push_back(c);
      q_flag.push_back(exp_flag);
      q_tag.push_back({ui ? "R1 " : "", req_of(op)});
   endtask

   // monitor: one quarter period after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q_res.size() > 0) begin
            logic [31:0] er;
            logic        ec, ef;
            string       tg;
            er = q_res.pop_front(); ec = q_cout.pop_front();
            ef = q_flag.pop_front(); tg = q_tag.pop_front();
            n_cmp++;
            if (result !== er || carry_out !== ec) begin
               n_bad++;
               $display("FAIL %s op=%0d result=%h carry=%b expected result=%h carry=%b",
                        tg, opcode, result, carry_out, er, ec);
            end
            n_cmp++;
            if (carry_flag !== ef) begin
               n_bad++;
               $display("FAIL R9 op=%0d carry_flag=%b expected %b", opcode, carry_flag, ef);
            end
         end
      end
   end

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #5;
      n_cmp++;
      if (carry_flag !== 1'b0) begin
         n_bad++;
         $display("FAIL R9 reset carry_flag=%b expected 0", carry_flag);
      end

      // R2 add and subtract edges
      drv(1, 4'd0, 32'hFFFF_FFFF, 32'h1, 16'h0, 0, 0);
      drv(1, 4'd2, 32'd3, 32'd5, 16'h0, 0, 0);
      drv(1, 4'd2, 32'd5, 32'd3, 16'h0, 0, 1);
      // R3 high forms and a 64-bit chain
      drv(1, 4'd1, 32'd5, 32'd7, 16'h0, 0, 1);
      drv(1, 4'd3, 32'd5, 32'd3, 16'h0, 0, 1);
      drv(1, 4'd3, 32'd0, 32'd0, 16'h0, 0, 1);
      drv(1, 4'd0, 32'h8000_0000, 32'h8000_0000, 16'h0, 0, 0);
      drv(1, 4'd1, 32'd1, 32'd2, 16'h0, 0, exp_flag);
      drv(1, 4'd2, 32'd0, 32'd1, 16'h0, 0, 0);
      drv(1, 4'd3, 32'd9, 32'd1, 16'h0, 0, exp_flag);
      // R10 reserved opcode keeps the flag that is now 0; set it to 1 first
      drv(1, 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 0, 0);
      drv(1, 4'd14, 32'h1234, 32'h5678, 16'h0, 0, 0);
      drv(1, 4'd15, 32'hFFFF_FFFF, 32'h1, 16'h0, 0, 1);
      // R9 invalid arithmetic does not update the flag
      drv(0, 4'd2, 32'd5, 32'd3, 16'h0, 0, 0);
      // R1 immediate zero-extension, R4 NOT ignores src1
      drv(1, 4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1, 0);
      drv(1, 4'd0, 32'h0000_0001, 32'hFFFF_FFFF, 16'hFFFF, 1, 0);
      drv(1, 4'd7, 32'hDEAD_BEEF, 32'h0, 16'h1234, 1, 0);
      drv(1, 4'd7, 32'h0, 32'hF0F0_0000, 16'h1234, 0, 0);
      // R5 shift amount masking and sign fill
      drv(1, 4'd8, 32'h0000_0003, 32'd33, 16'h0, 0, 0);
      drv(1, 4'd9, 32'h8000_0000, 32'hFFFF_FFE4, 16'h0, 0, 0);
      drv(1, 4'd10, 32'h8000_0000, 32'd4, 16'h0, 0, 0);
      drv(1, 4'd10, 32'h4000_0000, 32'd31, 16'h0, 0, 0);
      // R6 rotate
      drv(1, 4'd11, 32'h8000_0001, 32'd1, 16'h0, 0, 0);
      drv(1, 4'd11, 32'h1234_5678, 32'd0, 16'h0, 0, 0);
      drv(1, 4'd11, 32'h1234_5678, 32'd0, 16'd16, 1, 0);
      // R7 multiply low bytes
      drv(1, 4'd12, 32'h0000_01FF, 32'h0000_02FF, 16'h0, 0, 0);
      // R8 compare codes, unsigned near the sign bit
      drv(1, 4'd13, 32'd9, 32'd4, 16'h0, 0, 0);
      drv(1, 4'd13, 32'd4, 32'd4, 16'h0, 0, 0);
      drv(1, 4'd13, 32'd3, 32'd4, 16'h0, 0, 0);
      drv(1, 4'd13, 32'h8000_0000, 32'd1, 16'h0, 0, 0);
      drv(1, 4'd13, 32'h0001_0000, 32'h0, 16'hFFFF, 1, 0);

      for (int k = 0; k < 600; k++) begin
         drv(($urandom % 4) != 0, 4'($urandom % 16), $urandom, $urandom,
             16'($urandom), 1'($urandom % 2), 1'($urandom % 2));
      end

      @(negedge clk);
      op_valid = 1'b0;
      repeat (3) @(posedge clk);
      #6;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule